// File: doc/BRIEF.md
# Configuration Cycle Type Decoder

This block looks at the address phase of a bus transaction and works out what the bridge should do with a configuration access. It recognises a local (Type 0) access that the bridge must claim for one of its two configuration functions. It also recognises a hierarchical (Type 1) access, which some other logic forwards toward a downstream bus.

For a claimed access, the block gives the selected function and the DWORD register index. It also gives a per-byte lane mask for the data phase, and a request to disconnect after the first data transfer when the initiator wants more than one data phase. For a Type 1 access, it extracts the target bus number and device number. Register storage and forwarding are handled elsewhere.

All decisions are registered. The results appear on the outputs one clock after the cycle in which `addr_valid` is high.

Top module: `cfg_cycle_decoder`

## Requirements
- R1: `claim` is high one cycle after an address phase only when all of these hold: the command is configuration read (4'hA) or configuration write (4'hB), `ad[1:0]` is 2'b00, `idsel` is high, `from_secondary` is low, and the function number is below NUM_FUNCS. In every other case `claim` is low.
- R2: `type1` is high one cycle after an address phase whose command is configuration read or write and whose `ad[1:0]` is 2'b01. This holds whatever the values of `idsel` and `from_secondary`. `claim` and `type1` are never high together.
- R3: The function number is `ad[10:8]`. `func_sel` carries its low bit, so function 0 selects the first configuration space and function 1 selects the second. Function numbers 2 to 7 are never claimed.
- R4: `reg_index` equals `ad[7:2]` from the latest address phase. It holds its value while `addr_valid` is low.
- R5: `disconnect` is high exactly when `claim` is high and `more_phases` was high in that address phase. It is never high for an access that is not claimed.
- R6: `cfg_write` is high when the command was configuration write. `lane_en` is 4'hF for any other command, whatever `cbe_n` is. For a write, `lane_en` is the inverse of the active-low `cbe_n`.
- R7: An address phase marked `from_secondary` is never claimed.
- R8: `t1_bus` equals `ad[23:16]` and `t1_dev` equals `ad[15:11]` from the latest address phase.
- R9: In a cycle after one where `addr_valid` was low, `claim`, `type1` and `disconnect` are all low.
- R10: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_valid | input | 1 | High in the address-phase cycle |
| cmd | input | 4 | Bus command |
| ad | input | 32 | Address/data bus during the address phase |
| idsel | input | 1 | Configuration chip select |
| cbe_n | input | 4 | Active-low byte enables of the data phase |
| more_phases | input | 1 | Initiator requests more than one data phase |
| from_secondary | input | 1 | Access arrived on the secondary side |
| claim | output | 1 | Claim of a local Type 0 access |
| func_sel | output | 1 | Selected configuration function |
| reg_index | output | 6 | DWORD register index |
| cfg_write | output | 1 | Access is a configuration write |
| type1 | output | 1 | Type 1 access detected |
| t1_bus | output | 8 | Type 1 target bus number |
| t1_dev | output | 5 | Type 1 target device number |
| disconnect | output | 1 | Disconnect after the first data transfer |
| lane_en | output | 4 | Byte lanes that take part in the transfer |

## Verification
A claimed write can request several data phases and also carry partial byte enables. In that case the claim, the disconnect request and the masked lane enables must all appear on the same cycle. The table drives exactly this case, and a claimed read with multiple phases that drives all four lanes. Both are judged on the cycle after the address phase, against values the bench works out from the address and command on its own. Further vectors place a Type 1 access with `more_phases` high next to these. This confirms that the disconnect request does not leak onto an access that is not claimed.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
  localparam int AD_W     = 32;
  localparam int BE_W     = 4;
  localparam int REG_LSB  = 2;
  localparam int REG_W    = 6;
  localparam int FUNC_LSB = 8;
  localparam int FUNC_W   = 3;
  localparam int DEV_LSB  = 11;
  localparam int DEV_W    = 5;
  localparam int BUS_LSB  = 16;
  localparam int BUS_W    = 8;

  localparam logic [3:0] CMD_CFG_RD = 4'hA;
  localparam logic [3:0] CMD_CFG_WR = 4'hB;

  typedef enum logic [1:0] {
    KIND_LOCAL  = 2'b00,
    KIND_REMOTE = 2'b01,
    KIND_RSV2   = 2'b10,
    KIND_RSV3   = 2'b11
  } addr_kind_e;

  function automatic logic is_cfg_cmd(input logic [3:0] c);
    return (c == CMD_CFG_RD) || (c == CMD_CFG_WR);
  endfunction

  function automatic logic [REG_W-1:0] reg_of(input logic [AD_W-1:0] a);
    return a[REG_LSB +: REG_W];
  endfunction

  function automatic logic [FUNC_W-1:0] func_of(input logic [AD_W-1:0] a);
    return a[FUNC_LSB +: FUNC_W];
  endfunction

  function automatic logic [DEV_W-1:0] dev_of(input logic [AD_W-1:0] a);
    return a[DEV_LSB +: DEV_W];
  endfunction

  function automatic logic [BUS_W-1:0] bus_of(input logic [AD_W-1:0] a);
    return a[BUS_LSB +: BUS_W];
  endfunction
endpackage

// File: rtl/cfgdec_fields.sv
module cfgdec_fields
  import cfgdec_pkg::*;
(
  input  logic [AD_W-1:0]   ad,
  output addr_kind_e        kind,
  output logic [REG_W-1:0]  reg_num,
  output logic [FUNC_W-1:0] func_num,
  output logic [DEV_W-1:0]  dev_num,
  output logic [BUS_W-1:0]  bus_num
);
  logic unused_upper_bits;

  assign kind     = addr_kind_e'(ad[1:0]);
  assign reg_num  = reg_of(ad);
  assign func_num = func_of(ad);
  assign dev_num  = dev_of(ad);
  assign bus_num  = bus_of(ad);
  assign unused_upper_bits = ^ad[AD_W-1:BUS_LSB+BUS_W];
endmodule

// File: rtl/cfgdec_claim.sv
module cfgdec_claim
  import cfgdec_pkg::*;
#(
  parameter int NUM_FUNCS = 2
) (
  input  logic [3:0]        cmd,
  input  logic              idsel,
  input  logic              from_secondary,
  input  addr_kind_e        kind,
  input  logic [FUNC_W-1:0] func_num,
  output logic              cfg_cmd,
  output logic              func_in_range,
  output logic              local_hit,
  output logic              remote_hit
);
  assign cfg_cmd       = is_cfg_cmd(cmd);
  assign func_in_range = int'(func_num) < NUM_FUNCS;
  assign local_hit     = cfg_cmd && (kind == KIND_LOCAL) && idsel &&
                         !from_secondary && func_in_range;
  assign remote_hit    = cfg_cmd && (kind == KIND_REMOTE);

  always_comb begin
    AST_HITS_EXCLUSIVE: assert (!(local_hit && remote_hit)); // R2
  end
endmodule

// File: rtl/cfgdec_lanes.sv
module cfgdec_lanes #(
  parameter int BE_W = 4
) (
  input  logic            is_write,
  input  logic [BE_W-1:0] cbe_n,
  output logic [BE_W-1:0] lanes
);
  for (genvar i = 0; i < BE_W; i++) begin : g_lane
    assign lanes[i] = is_write ? !cbe_n[i] : 1'b1;
  end
endmodule

// File: rtl/cfg_cycle_decoder.sv
module cfg_cycle_decoder
  import cfgdec_pkg::*;
#(
  parameter int NUM_FUNCS = 2,
  localparam int FSEL_W = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_valid,
  input  logic [3:0]        cmd,
  input  logic [AD_W-1:0]   ad,
  input  logic              idsel,
  input  logic [BE_W-1:0]   cbe_n,
  input  logic              more_phases,
  input  logic              from_secondary,
  output logic              claim,
  output logic [FSEL_W-1:0] func_sel,
  output logic [REG_W-1:0]  reg_index,
  output logic              cfg_write,
  output logic              type1,
  output logic [BUS_W-1:0]  t1_bus,
  output logic [DEV_W-1:0]  t1_dev,
  output logic              disconnect,
  output logic [BE_W-1:0]   lane_en
);
  addr_kind_e        kind;
  logic [REG_W-1:0]  reg_num;
  logic [FUNC_W-1:0] func_num;
  logic [DEV_W-1:0]  dev_num;
  logic [BUS_W-1:0]  bus_num;
  logic              cfg_cmd, func_in_range, local_hit, remote_hit;
  logic              write_cmd;
  logic [BE_W-1:0]   lanes_nxt;

  cfgdec_fields u_fields (
    .ad       (ad),
    .kind     (kind),
    .reg_num  (reg_num),
    .func_num (func_num),
    .dev_num  (dev_num),
    .bus_num  (bus_num)
  );

  cfgdec_claim #(.NUM_FUNCS(NUM_FUNCS)) u_claim (
    .cmd            (cmd),
    .idsel          (idsel),
    .from_secondary (from_secondary),
    .kind           (kind),
    .func_num       (func_num),
    .cfg_cmd        (cfg_cmd),
    .func_in_range  (func_in_range),
    .local_hit      (local_hit),
    .remote_hit     (remote_hit)
  );

  assign write_cmd = (cmd == CMD_CFG_WR);

  cfgdec_lanes #(.BE_W(BE_W)) u_lanes (
    .is_write (write_cmd),
    .cbe_n    (cbe_n),
    .lanes    (lanes_nxt)
  );

  // Named events for the assertions
  logic take_claim, take_remote, take_disc;
  assign take_claim  = addr_valid && local_hit;
  assign take_remote = addr_valid && remote_hit;
  assign take_disc   = take_claim && more_phases;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      claim      <= 1'b0;
      type1      <= 1'b0;
      disconnect <= 1'b0;
      func_sel   <= '0;
      reg_index  <= '0;
      cfg_write  <= 1'b0;
      t1_bus     <= '0;
      t1_dev     <= '0;
      lane_en    <= '0;
    end else begin
      claim      <= take_claim;
      type1      <= take_remote;
      disconnect <= take_disc;
      if (addr_valid) begin
        func_sel  <= func_num[FSEL_W-1:0];
        reg_index <= reg_num;
        cfg_write <= write_cmd;
        t1_bus    <= bus_num;
        t1_dev    <= dev_num;
        lane_en   <= lanes_nxt;
      end
    end
  end

  AST_CLAIM_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> $past(addr_valid && idsel && cfg_cmd && ad[1:0] == 2'b00)); // R1
  AST_NO_DUAL_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    !(claim && type1)); // R2
  AST_FUNC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> $past(int'(ad[FUNC_LSB +: FUNC_W]) < NUM_FUNCS)); // R3
  AST_DISC_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    disconnect |-> claim); // R5
  AST_READ_FULL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && !cfg_write) |-> (lane_en == {BE_W{1'b1}})); // R6
  AST_SEC_NEVER_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> !$past(from_secondary)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(addr_valid) |-> !(claim || type1 || disconnect)); // R9
  AST_HOLD_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(addr_valid) |-> $stable(reg_index)); // R4
endmodule

// File: tb/cfg_cycle_decoder_tb.sv
module cfg_cycle_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_valid = 1'b0;
  logic [3:0]  cmd = '0;
  logic [31:0] ad = '0;
  logic        idsel = 1'b0;
  logic [3:0]  cbe_n = '0;
  logic        more_phases = 1'b0;
  logic        from_secondary = 1'b0;
  logic        claim, cfg_write, type1, disconnect;
  logic [0:0]  func_sel;
  logic [5:0]  reg_index;
  logic [7:0]  t1_bus;
  logic [4:0]  t1_dev;
  logic [3:0]  lane_en;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cfg_cycle_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .cmd(cmd), .ad(ad),
    .idsel(idsel), .cbe_n(cbe_n), .more_phases(more_phases),
    .from_secondary(from_secondary), .claim(claim), .func_sel(func_sel),
    .reg_index(reg_index), .cfg_write(cfg_write), .type1(type1),
    .t1_bus(t1_bus), .t1_dev(t1_dev), .disconnect(disconnect), .lane_en(lane_en)
  );

  typedef struct packed {
    logic [3:0]  cmd;
    logic [31:0] ad;
    logic        idsel;
    logic [3:0]  cbe_n;
    logic        more;
    logic        sec;
    logic        x_claim;
    logic        x_t1;
    logic        x_disc;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{4'hA, 32'h0000_0010, 1'b1, 4'b0110, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{4'hB, 32'h0000_0134, 1'b1, 4'b1010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    '{4'hA, 32'h0000_0210, 1'b1, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'hA, 32'h0000_0010, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'hA, 32'h0000_0012, 1'b1, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'h6, 32'h0000_0010, 1'b1, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'hA, 32'h0012_5A41, 1'b0, 4'b1111, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{4'hB, 32'h00FF_F8FD, 1'b1, 4'b0011, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{4'hA, 32'h0000_0010, 1'b1, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{4'h7, 32'h0012_5A41, 1'b1, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'hA, 32'h0003_0801, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{4'hA, 32'h0000_0110, 1'b1, 4'b0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int last_reg;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk({claim, type1, disconnect, cfg_write} == 4'b0, "R10 flags", int'({claim, type1, disconnect, cfg_write}), 0);
    chk(reg_index == 0 && lane_en == 0 && t1_bus == 0 && t1_dev == 0, "R10 fields",
        int'(reg_index) + int'(lane_en) + int'(t1_bus) + int'(t1_dev), 0);
    rst_n = 1'b1;
    last_reg = 0;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      @(negedge clk);
      addr_valid = 1'b1; cmd = v.cmd; ad = v.ad; idsel = v.idsel;
      cbe_n = v.cbe_n; more_phases = v.more; from_secondary = v.sec;
      @(negedge clk);
      addr_valid = 1'b0;
      chk(claim == v.x_claim, "R1 R3 R7 claim", int'(claim), int'(v.x_claim));
      chk(type1 == v.x_t1, "R2 type1", int'(type1), int'(v.x_t1));
      chk(disconnect == v.x_disc, "R5 disconnect", int'(disconnect), int'(v.x_disc));
      chk(reg_index == 6'((v.ad / 4) % 64), "R4 reg_index", int'(reg_index), int'((v.ad / 4) % 64));
      chk(cfg_write == (v.cmd == 4'hB), "R6 cfg_write", int'(cfg_write), int'(v.cmd == 4'hB));
      chk(lane_en == ((v.cmd == 4'hB) ? (4'hF ^ v.cbe_n) : 4'hF), "R6 lane_en",
          int'(lane_en), int'((v.cmd == 4'hB) ? (4'hF ^ v.cbe_n) : 4'hF));
      if (v.x_claim)
        chk(func_sel == 1'((v.ad / 256) % 2), "R3 func_sel", int'(func_sel), int'((v.ad / 256) % 2));
      if (v.x_t1) begin
        chk(t1_bus == 8'((v.ad / 65536) % 256), "R8 t1_bus", int'(t1_bus), int'((v.ad / 65536) % 256));
        chk(t1_dev == 5'((v.ad / 2048) % 32), "R8 t1_dev", int'(t1_dev), int'((v.ad / 2048) % 32));
      end
      last_reg = int'((v.ad / 4) % 64);
    end

    // R9: no address phase, claimable pattern held on the bus
    cmd = 4'hA; ad = 32'h0000_0024; idsel = 1'b1; more_phases = 1'b1; from_secondary = 1'b0;
    @(negedge clk);
    chk(!claim && !type1 && !disconnect, "R9 idle flags", int'({claim, type1, disconnect}), 0);
    chk(reg_index == 6'(last_reg), "R4 hold while idle", int'(reg_index), last_reg);

    // R10: reset asserted after activity clears outputs
    addr_valid = 1'b1;
    @(negedge clk);
    addr_valid = 1'b0;
    chk(claim && disconnect && reg_index == 6'd9, "R1 R5 final claim", int'({claim, disconnect}), 3);
    rst_n = 1'b0;
    #1;
    chk(!claim && !disconnect && reg_index == 0, "R10 async clear", int'({claim, disconnect}), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule